// File: doc/BRIEF.md
# Codec Command Slot Interface

This block lets software issue register commands to an external audio codec through two frame-slot registers. Software writes a data word into the slot-2 transmit register and then a command word into the slot-1 transmit register. The slot-1 write launches exactly one command on a request/acknowledge port toward the codec. A bit in the command word selects read or write, and a fixed field carries the 7-bit codec register address. The 16-bit write data comes from a fixed field of the slot-2 word.

When a read command is acknowledged, the block fills two receive registers. Slot-1 receive holds the command word with its read/write bit cleared. Slot-2 receive holds the returned value moved up by four bit positions. A flag register shows, per slot, whether the transmit register has been consumed, whether a reply is pending and whether a reply has arrived. A slot-1 write that lands while a command is still outstanding is parked in a one-deep holding register. It is issued in the cycle after the codec acknowledges the earlier command.

Top module: `codec_cmd_slots`

## Requirements
- R1: After reset the flag register reads 0x07 and `cmdValid` is low. Flag bits are: bit0 slot-1 transmit empty, bit1 slot-2 transmit empty, bit2 both-transmit empty, bit3 slot-1 receive busy, bit4 slot-2 receive busy, bit5 slot-1 receive valid, bit6 slot-2 receive valid. Register select codes are: 0 slot-1 transmit, 1 slot-2 transmit, 2 slot-1 receive, 3 slot-2 receive, 4 flags.
- R2: A slot-1 write with bit 19 = 0, accepted with no command outstanding, raises `cmdValid` in the next cycle with `cmdRead` = 0. In that cycle `cmdAddr` equals bits 18:12 of the slot-1 word and `cmdData` equals bits 19:4 of the slot-2 transmit register.
- R3: A slot-1 write with bit 19 = 1 issues a command with `cmdRead` = 1 and the address from bits 18:12.
- R4: When a read command is acknowledged, slot-1 receive becomes the command word with bit 19 cleared. Slot-2 receive becomes `rspData` shifted left by 4, with bits 3:0 zero.
- R5: Both receive-busy flags are set while a read command is outstanding. At its acknowledge both busy flags clear and both receive-valid flags set.
- R6: A slot-2 write clears flag bits 1 and 2. A slot-1 write clears flag bits 0 and 2.
- R7: While `cmdValid` is high and `cmdAck` is low, `cmdValid`, `cmdRead`, `cmdAddr` and `cmdData` hold their values into the next cycle.
- R8: A slot-1 write accepted while a command is outstanding is held back. It appears on the command port in the cycle after the earlier acknowledge, and slot-1 transmit empty stays clear through that acknowledge.
- R9: The three transmit-empty flags set again at an acknowledge that leaves no command outstanding.
- R10: Reading slot-1 receive clears only bit 5, and reading slot-2 receive clears only bit 6.
- R11: Acknowledging a write command changes neither receive register nor the receive-valid flags.
- R12: `cmdAck` while `cmdValid` is low has no effect on the flags or the receive registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for writes |
| wrData | input | 20 | Register write data |
| rdEn | input | 1 | Register read strobe (clears receive-valid flags) |
| rdSel | input | 3 | Register select for reads |
| rdData | output | 20 | Read data for `rdSel`, combinational |
| cmdValid | output | 1 | Command request toward the codec |
| cmdRead | output | 1 | 1 = read command, 0 = write command |
| cmdAddr | output | 7 | Codec register address |
| cmdData | output | 16 | Write data for the codec |
| cmdAck | input | 1 | Codec acknowledges the current command |
| rspData | input | 16 | Read result, valid with `cmdAck` |

## Verification
The assertions assume the codec raises `cmdAck` only as a single-cycle pulse and drives `rspData` in the same cycle. They also assume the register port issues at most one write per cycle. The stimulus drives every acknowledge through one task that holds `cmdAck` for exactly one clock with the response word alongside it. One deliberately stray pulse, sent while no command is outstanding, confirms that acknowledges outside a command are ignored. All register accesses go through single-cycle write and read tasks.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [2:0] {
    SEL_S1_TX = 3'd0,
    SEL_S2_TX = 3'd1,
    SEL_S1_RX = 3'd2,
    SEL_S2_RX = 3'd3,
    SEL_FLAGS = 3'd4
  } regSel_e;

  localparam int FLAG_W      = 7;
  localparam int F_S1_EMPTY  = 0;
  localparam int F_S2_EMPTY  = 1;
  localparam int F_ALL_EMPTY = 2;
  localparam int F_S1_BUSY   = 3;
  localparam int F_S2_BUSY   = 4;
  localparam int F_S1_VALID  = 5;
  localparam int F_S2_VALID  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic loadS1Tx;
    logic loadS2Tx;
    logic launchNew;
    logic launchDefer;
    logic storeDefer;
    logic captureRsp;
  } slotStrobe_t;

endpackage

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic              rdEn,
  input  logic [2:0]        rdSel,
  input  logic              wrIsRead,
  input  logic              deferIsRead,
  input  logic              activeIsRead,
  input  logic              cmdAck,
  output slotStrobe_t       strobe,
  output logic              cmdValid,
  output logic [FLAG_W-1:0] flags
);

  logic busy;
  logic deferFull;
  logic s1Write, s2Write, ackNow, busyNext, readLaunch, idleAfter;
  logic s1Empty, s2Empty, allEmpty, rxBusy, s1Valid, s2Valid;

  always_comb begin
    s1Write = wrEn && (wrSel == SEL_S1_TX);
    s2Write = wrEn && (wrSel == SEL_S2_TX);
    ackNow  = busy && cmdAck;

    strobe.loadS1Tx    = s1Write;
    strobe.loadS2Tx    = s2Write;
    strobe.launchNew   = s1Write && (!busy || (ackNow && !deferFull));
    strobe.launchDefer = ackNow && deferFull;
    strobe.storeDefer  = s1Write && !strobe.launchNew;
    strobe.captureRsp  = ackNow && activeIsRead;

    busyNext   = strobe.launchNew || strobe.launchDefer || (busy && !ackNow);
    readLaunch = (strobe.launchNew && wrIsRead) || (strobe.launchDefer && deferIsRead);
    idleAfter  = ackNow && !busyNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      deferFull <= 1'b0;
    end else begin
      busy      <= busyNext;
      deferFull <= strobe.storeDefer || (deferFull && !strobe.launchDefer);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Empty  <= 1'b1;
      s2Empty  <= 1'b1;
      allEmpty <= 1'b1;
      rxBusy   <= 1'b0;
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
    end else begin
      if (s1Write)        s1Empty <= 1'b0;
      else if (idleAfter) s1Empty <= 1'b1;

      if (s2Write)        s2Empty <= 1'b0;
      else if (idleAfter) s2Empty <= 1'b1;

      if (s1Write || s2Write) allEmpty <= 1'b0;
      else if (idleAfter)     allEmpty <= 1'b1;

      if (readLaunch)             rxBusy <= 1'b1;
      else if (strobe.captureRsp) rxBusy <= 1'b0;

      if (strobe.captureRsp)                     s1Valid <= 1'b1;
      else if (rdEn && (rdSel == SEL_S1_RX))     s1Valid <= 1'b0;

      if (strobe.captureRsp)                     s2Valid <= 1'b1;
      else if (rdEn && (rdSel == SEL_S2_RX))     s2Valid <= 1'b0;
    end
  end

  always_comb begin
    flags              = '0;
    flags[F_S1_EMPTY]  = s1Empty;
    flags[F_S2_EMPTY]  = s2Empty;
    flags[F_ALL_EMPTY] = allEmpty;
    flags[F_S1_BUSY]   = rxBusy;
    flags[F_S2_BUSY]   = rxBusy;
    flags[F_S1_VALID]  = s1Valid;
    flags[F_S2_VALID]  = s2Valid;
  end

  assign cmdValid = busy;

endmodule

// File: rtl/ccs_datapath.sv
module ccs_datapath
  import ccs_pkg::*;
#(
  parameter int SLOT_W   = 20,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int RW_BIT   = 19,
  parameter int ADDR_LSB = 12,
  parameter int DATA_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobe_t       strobe,
  input  logic [SLOT_W-1:0] wrData,
  input  logic [DATA_W-1:0] rspData,
  input  logic [2:0]        rdSel,
  input  logic [FLAG_W-1:0] flags,
  output logic [SLOT_W-1:0] rdData,
  output logic [SLOT_W-1:0] s1RxWord,
  output logic [SLOT_W-1:0] s2RxWord,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              activeIsRead,
  output logic              deferIsRead
);

  localparam int PAD_W = SLOT_W - FLAG_W;

  logic [SLOT_W-1:0] s1Tx, s2Tx, deferWord, activeWord, echoWord, rspWord;
  logic [DATA_W-1:0] cmdDataQ;

  always_comb begin
    echoWord         = activeWord;
    echoWord[RW_BIT] = 1'b0;
    rspWord          = SLOT_W'(rspData) << DATA_LSB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Tx       <= '0;
      s2Tx       <= '0;
      deferWord  <= '0;
      activeWord <= '0;
      cmdDataQ   <= '0;
      s1RxWord   <= '0;
      s2RxWord   <= '0;
    end else begin
      if (strobe.loadS1Tx)   s1Tx      <= wrData;
      if (strobe.loadS2Tx)   s2Tx      <= wrData;
      if (strobe.storeDefer) deferWord <= wrData;
      if (strobe.launchNew) begin
        activeWord <= wrData;
        cmdDataQ   <= s2Tx[DATA_LSB +: DATA_W];
      end else if (strobe.launchDefer) begin
        activeWord <= deferWord;
        cmdDataQ   <= s2Tx[DATA_LSB +: DATA_W];
      end
      if (strobe.captureRsp) begin
        s1RxWord <= echoWord;
        s2RxWord <= rspWord;
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_S1_TX: rdData = s1Tx;
      SEL_S2_TX: rdData = s2Tx;
      SEL_S1_RX: rdData = s1RxWord;
      SEL_S2_RX: rdData = s2RxWord;
      SEL_FLAGS: rdData = {{PAD_W{1'b0}}, flags};
      default:   rdData = '0;
    endcase
  end

  assign cmdRead      = activeWord[RW_BIT];
  assign cmdAddr      = activeWord[ADDR_LSB +: ADDR_W];
  assign cmdData      = cmdDataQ;
  assign activeIsRead = activeWord[RW_BIT];
  assign deferIsRead  = deferWord[RW_BIT];

endmodule

// File: rtl/codec_cmd_slots.sv
module codec_cmd_slots
  import ccs_pkg::*;
#(
  parameter int SLOT_W   = 20,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int RW_BIT   = 19,
  parameter int ADDR_LSB = 12,
  parameter int DATA_LSB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [SLOT_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [2:0]        rdSel,
  output logic [SLOT_W-1:0] rdData,
  output logic              cmdValid,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdAck,
  input  logic [DATA_W-1:0] rspData
);

  slotStrobe_t       strobe;
  logic [FLAG_W-1:0] flags;
  logic [SLOT_W-1:0] s1RxWord, s2RxWord;
  logic              activeIsRead, deferIsRead;

  ccs_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrSel        (wrSel),
    .rdEn         (rdEn),
    .rdSel        (rdSel),
    .wrIsRead     (wrData[RW_BIT]),
    .deferIsRead  (deferIsRead),
    .activeIsRead (activeIsRead),
    .cmdAck       (cmdAck),
    .strobe       (strobe),
    .cmdValid     (cmdValid),
    .flags        (flags)
  );

  ccs_datapath #(
    .SLOT_W   (SLOT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RW_BIT   (RW_BIT),
    .ADDR_LSB (ADDR_LSB),
    .DATA_LSB (DATA_LSB)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .rspData      (rspData),
    .rdSel        (rdSel),
    .flags        (flags),
    .rdData       (rdData),
    .s1RxWord     (s1RxWord),
    .s2RxWord     (s2RxWord),
    .cmdRead      (cmdRead),
    .cmdAddr      (cmdAddr),
    .cmdData      (cmdData),
    .activeIsRead (activeIsRead),
    .deferIsRead  (deferIsRead)
  );

endmodule

// File: rtl/codec_cmd_slots_chk.sv
module codec_cmd_slots_chk
  import ccs_pkg::*;
#(
  parameter int SLOT_W   = 20,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int RW_BIT   = 19,
  parameter int ADDR_LSB = 12,
  parameter int DATA_LSB = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrSel,
  input logic              cmdValid,
  input logic              cmdRead,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdData,
  input logic              cmdAck,
  input logic [DATA_W-1:0] rspData,
  input logic [FLAG_W-1:0] flags,
  input logic [SLOT_W-1:0] s1RxWord,
  input logic [SLOT_W-1:0] s2RxWord
);

  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdAck |=> cmdValid && $stable(cmdRead) && $stable(cmdAddr) && $stable(cmdData));

  a_r5_busy_while_read: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdRead |-> flags[F_S1_BUSY] && flags[F_S2_BUSY]);

  a_r5_valid_on_done: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdAck && cmdRead |=> flags[F_S1_VALID] && flags[F_S2_VALID]);

  a_r4_rx_fill: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdAck && cmdRead |=>
      !s1RxWord[RW_BIT] && (s1RxWord[ADDR_LSB +: ADDR_W] == $past(cmdAddr)) &&
      (s2RxWord == (SLOT_W'($past(rspData)) << DATA_LSB)));

  a_r6_s1_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrSel == SEL_S1_TX) |=> !flags[F_S1_EMPTY] && !flags[F_ALL_EMPTY]);

  a_r12_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid && cmdAck |=> $stable(s1RxWord) && $stable(s2RxWord));

  a_r11_write_keeps_rx: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdAck && !cmdRead |=> $stable(s1RxWord) && $stable(s2RxWord));

endmodule

bind codec_cmd_slots codec_cmd_slots_chk #(
  .SLOT_W   (SLOT_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .RW_BIT   (RW_BIT),
  .ADDR_LSB (ADDR_LSB),
  .DATA_LSB (DATA_LSB)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .cmdValid (cmdValid),
  .cmdRead  (cmdRead),
  .cmdAddr  (cmdAddr),
  .cmdData  (cmdData),
  .cmdAck   (cmdAck),
  .rspData  (rspData),
  .flags    (flags),
  .s1RxWord (s1RxWord),
  .s2RxWord (s2RxWord)
);

// File: tb/test_codec_cmd_slots.sv
`timescale 1ns/1ps
module test_codec_cmd_slots;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [19:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdSel = 3'd4;
  logic [19:0] rdData;
  logic        cmdValid, cmdRead;
  logic [6:0]  cmdAddr;
  logic [15:0] cmdData;
  logic        cmdAck = 1'b0;
  logic [15:0] rspData = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  codec_cmd_slots i_codec_cmd_slots (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .cmdValid(cmdValid),
    .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .cmdAck(cmdAck), .rspData(rspData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [19:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // peek without side effects (flags / tx registers)
  task automatic peek(input logic [2:0] sel, output logic [19:0] d);
    rdSel = sel;
    #0.5;
    d = rdData;
  endtask

  // read with the strobe, which clears receive-valid flags
  task automatic readReg(input logic [2:0] sel, output logic [19:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdSel = sel;
    #0.5;
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ackPulse(input logic [15:0] r);
    @(negedge clk);
    cmdAck = 1'b1; rspData = r;
    @(negedge clk);
    cmdAck = 1'b0; rspData = '0;
  endtask

  task automatic testReset();
    logic [19:0] d;
    peek(3'd4, d);
    check("R1 flags after reset", 32'(d), 32'h07);
    check("R1 cmdValid after reset", 32'(cmdValid), 32'h0);
  endtask

  task automatic testWriteCmd();
    logic [19:0] d;
    writeReg(3'd1, 20'hABCD5);
    peek(3'd4, d);
    check("R6 slot2 write clears bits1,2", 32'(d), 32'h01);
    writeReg(3'd0, 20'h2A123);
    check("R2 cmdValid", 32'(cmdValid), 32'h1);
    check("R2 cmdRead", 32'(cmdRead), 32'h0);
    check("R2 cmdAddr", 32'(cmdAddr), 32'h2A);
    check("R2 cmdData", 32'(cmdData), 32'hABCD);
    peek(3'd4, d);
    check("R6 slot1 write clears bits0,2", 32'(d), 32'h00);
    repeat (3) @(negedge clk);
    check("R7 held valid", 32'(cmdValid), 32'h1);
    check("R7 held addr", 32'(cmdAddr), 32'h2A);
    check("R7 held data", 32'(cmdData), 32'hABCD);
    ackPulse(16'h7777);
    check("R9 cmdValid drops", 32'(cmdValid), 32'h0);
    peek(3'd4, d);
    check("R9 empties set at ack / R11 no valid", 32'(d), 32'h07);
    peek(3'd2, d);
    check("R11 slot1 rx untouched", 32'(d), 32'h0);
    peek(3'd3, d);
    check("R11 slot2 rx untouched", 32'(d), 32'h0);
  endtask

  task automatic testReadCmd();
    logic [19:0] d;
    writeReg(3'd0, 20'h950FF);
    check("R3 cmdRead", 32'(cmdRead), 32'h1);
    check("R3 cmdAddr", 32'(cmdAddr), 32'h15);
    peek(3'd4, d);
    check("R5 busy while pending", 32'(d), 32'h1A);
    ackPulse(16'h1234);
    peek(3'd4, d);
    check("R5 valid set busy clear", 32'(d), 32'h67);
    readReg(3'd2, d);
    check("R4 slot1 rx echo", 32'(d), 32'h150FF);
    peek(3'd4, d);
    check("R10 slot1 rx read clears bit5 only", 32'(d), 32'h47);
    readReg(3'd3, d);
    check("R4 slot2 rx shifted", 32'(d), 32'h12340);
    peek(3'd4, d);
    check("R10 slot2 rx read clears bit6", 32'(d), 32'h07);
  endtask

  task automatic testDeferred();
    logic [19:0] d;
    writeReg(3'd0, 20'h01000);
    writeReg(3'd0, 20'h82000);
    check("R8 first cmd still shown", 32'(cmdAddr), 32'h01);
    check("R8 first cmd is write", 32'(cmdRead), 32'h0);
    ackPulse(16'h0000);
    check("R8 deferred cmd issued", 32'(cmdValid), 32'h1);
    check("R8 deferred addr", 32'(cmdAddr), 32'h02);
    check("R8 deferred is read", 32'(cmdRead), 32'h1);
    check("R8 deferred data from slot2", 32'(cmdData), 32'hABCD);
    peek(3'd4, d);
    check("R8 slot1 empty stays clear", 32'(d), 32'h1A);
    ackPulse(16'hBEEF);
    peek(3'd4, d);
    check("R9 flags after final ack", 32'(d), 32'h67);
    readReg(3'd2, d);
    check("R4 deferred slot1 rx", 32'(d), 32'h02000);
    readReg(3'd3, d);
    check("R4 deferred slot2 rx", 32'(d), 32'hBEEF0);
  endtask

  task automatic testStrayAck();
    logic [19:0] d;
    ackPulse(16'h5555);
    peek(3'd4, d);
    check("R12 flags unchanged", 32'(d), 32'h07);
    peek(3'd3, d);
    check("R12 slot2 rx unchanged", 32'(d), 32'hBEEF0);
    check("R12 no command", 32'(cmdValid), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteCmd();
    testReadCmd();
    testDeferred();
    testStrayAck();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule